// File: doc/BRIEF.md
# Selectable Prescaler with Programmable Divide-by-N Chain

This block is the feedback divider for a frequency-synthesis loop. Two counting stages run in one clock domain, and every rising edge of `clk` is one input edge of the chain. The first stage is a prescaler whose ratio is one of four values (4, 16, 64 or 100), picked by two select pins. The second stage is a 4-bit divide-by-N counter. Its N is taken from a preset bus while a preset-enable pin is high.

A mode pin picks one of two routings. In cascade mode the prescaler output drives the second stage, and the second-stage output goes to the comparator-feed output. In independent mode the prescaler output goes straight to the comparator feed, so the prescaler can work with a divider outside the block. The second stage is then advanced by a separate tick input. Both stage outputs are always visible. Each output is a pulse one input-clock cycle wide, issued once per completed division.

A new ratio or a new N is taken only at that stage's terminal count, so a period is never cut short. An N of zero is not legal. In that case the second stage holds its output low and raises an error flag until a non-zero value is loaded.

Top module: `divchain_top`

## Requirements
- R1: The prescaler period in `clk` cycles is set by {`sel_hi`,`sel_lo`}: 2'b00 gives 4, 2'b01 gives 16, 2'b10 gives 64, 2'b11 gives 100 (a modulo-100 count).
- R2: `pre_pulse` is high for exactly one `clk` cycle per prescaler period. In cascade mode `div_pulse` is high for one cycle per second-stage period.
- R3: The second stage emits one `div_pulse` for every N of its advance enables. N is `preset[3:0]`, with bit 0 the least significant, and any value from 1 to 15 is allowed.
- R4: With `cascade_mode`=1 the second stage advances on `pre_pulse`, and `cmp_feed` equals `div_pulse`, giving a period of ratio*N cycles.
- R5: With `cascade_mode`=0 the second stage advances only on `aux_tick`, and `cmp_feed` equals `pre_pulse`, giving a period equal to the ratio.
- R6: While `preset_en`=1, a new `preset` is taken at the second stage's next terminal count. While `preset_en`=0, changes on `preset` have no effect.
- R7: A change on the select pins takes effect only after the next `pre_pulse`, so the period in progress completes at its old length.
- R8: While the stored N is 0, `zero_err`=1 and `div_pulse` stays low. A non-zero `preset` with `preset_en`=1 is loaded on the next advance enable, and that load clears `zero_err`.
- R9: `rst` is synchronous and active high. It clears both counters and captures the select pins and `preset`. No `pre_pulse` occurs in the cycle after a reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain input clock; each rising edge is one counted edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_hi | input | 1 | Prescaler ratio select, high bit |
| sel_lo | input | 1 | Prescaler ratio select, low bit |
| preset | input | 4 | Divide-by-N value for the second stage |
| preset_en | input | 1 | Allows `preset` to be loaded at terminal count |
| cascade_mode | input | 1 | 1: cascade the stages; 0: second stage independent |
| aux_tick | input | 1 | Second-stage advance enable in independent mode |
| pre_pulse | output | 1 | Prescaler terminal-count pulse |
| div_pulse | output | 1 | Second-stage terminal-count pulse |
| cmp_feed | output | 1 | Comparator-feed pulse, routed by `cascade_mode` |
| zero_err | output | 1 | High while the stored N is zero |

## Verification
The hardest cases to reach from the ports are control changes that arrive in the middle of a period: a ratio switch partway through a divide-by-100 count, a new preset while a ratio*N period is in progress, and recovery from a zero preset. The stimulus first waits for an observed output pulse. It then changes the input a known number of cycles later and measures the next two periods. The first period must keep the old length and the second must take the new one. A full sweep of every ratio against every N from 1 to 15 in cascade mode checks that the periods multiply.

// File: rtl/divchain_pkg.sv
package divchain_pkg;

  // Prescaler ratio codes as seen on {sel_hi, sel_lo}
  typedef enum logic [1:0] {
    SEL_R0 = 2'b00,
    SEL_R1 = 2'b01,
    SEL_R2 = 2'b10,
    SEL_R3 = 2'b11
  } ratio_sel_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/divchain_prescale.sv
module divchain_prescale
  import divchain_pkg::*;
#(
  parameter int RATIO0 = 4,
  parameter int RATIO1 = 16,
  parameter int RATIO2 = 64,
  parameter int RATIO3 = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  ratio_sel_e sel,
  output logic       pulse
);
  localparam int MAXR = max4(RATIO0, RATIO1, RATIO2, RATIO3);
  localparam int CW   = $clog2(MAXR);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term_q;
  logic [CW-1:0] term_next;

  always_comb begin
    unique case (sel)
      SEL_R0:  term_next = CW'(RATIO0 - 1);
      SEL_R1:  term_next = CW'(RATIO1 - 1);
      SEL_R2:  term_next = CW'(RATIO2 - 1);
      default: term_next = CW'(RATIO3 - 1);
    endcase
  end

  assign pulse = (cnt_q == term_q);

  // The new terminal value is latched only at terminal count, never mid-period
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      term_q <= term_next;
    end else if (pulse) begin
      cnt_q  <= '0;
      term_q <= term_next;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/divchain_progdiv.sv
module divchain_progdiv #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [NW-1:0] preset,
  input  logic          preset_en,
  output logic          pulse,
  output logic          zero_err
);
  logic [NW-1:0] cnt_q;
  logic [NW-1:0] n_q;
  logic          zero;
  logic          at_term;

  assign zero     = (n_q == '0);
  assign at_term  = (cnt_q == n_q - NW'(1));
  assign pulse    = adv && !zero && at_term;
  assign zero_err = zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      n_q   <= preset;
    end else if (adv) begin
      if (zero) begin
        // An illegal zero count waits for a legal value, one enable at a time
        if (preset_en) n_q <= preset;
      end else if (at_term) begin
        cnt_q <= '0;
        if (preset_en) n_q <= preset;
      end else begin
        cnt_q <= cnt_q + NW'(1);
      end
    end
  end

endmodule

// File: rtl/divchain_route.sv
module divchain_route (
  input  logic cascade_mode,
  input  logic pre_pulse,
  input  logic aux_tick,
  input  logic div_pulse,
  output logic stage2_adv,
  output logic cmp_feed
);
  always_comb begin
    if (cascade_mode) begin
      stage2_adv = pre_pulse;
      cmp_feed   = div_pulse;
    end else begin
      stage2_adv = aux_tick;
      cmp_feed   = pre_pulse;
    end
  end
endmodule

// File: rtl/divchain_top.sv
module divchain_top
  import divchain_pkg::*;
#(
  parameter int RATIO0 = 4,
  parameter int RATIO1 = 16,
  parameter int RATIO2 = 64,
  parameter int RATIO3 = 100,
  parameter int NW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_hi,
  input  logic          sel_lo,
  input  logic [NW-1:0] preset,
  input  logic          preset_en,
  input  logic          cascade_mode,
  input  logic          aux_tick,
  output logic          pre_pulse,
  output logic          div_pulse,
  output logic          cmp_feed,
  output logic          zero_err
);
  ratio_sel_e sel;
  logic       stage2_adv;

  assign sel = ratio_sel_e'({sel_hi, sel_lo});

  divchain_prescale #(
    .RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2), .RATIO3(RATIO3)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .pulse(pre_pulse)
  );

  divchain_progdiv #(.NW(NW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .adv      (stage2_adv),
    .preset   (preset),
    .preset_en(preset_en),
    .pulse    (div_pulse),
    .zero_err (zero_err)
  );

  divchain_route u_route (
    .cascade_mode(cascade_mode),
    .pre_pulse   (pre_pulse),
    .aux_tick    (aux_tick),
    .div_pulse   (div_pulse),
    .stage2_adv  (stage2_adv),
    .cmp_feed    (cmp_feed)
  );

endmodule

// File: rtl/divchain_chk.sv
module divchain_chk #(
  parameter int RATIO0 = 4,
  parameter int RATIO1 = 16,
  parameter int RATIO2 = 64,
  parameter int RATIO3 = 100
) (
  input logic clk,
  input logic rst,
  input logic cascade_mode,
  input logic aux_tick,
  input logic pre_pulse,
  input logic div_pulse,
  input logic zero_err
);
  // Cycles since the previous prescaler pulse, saturating
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= 8'd0;
      seen_q <= 1'b0;
    end else if (pre_pulse) begin
      gap_q  <= 8'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hFF) begin
      gap_q  <= gap_q + 8'd1;
    end
  end

  // R1: every prescaler interval is one of the selectable ratios
  a_r1_ratio_gap: assert property (@(posedge clk) disable iff (rst)
    (pre_pulse && seen_q) |-> (gap_q == 8'(RATIO0) || gap_q == 8'(RATIO1) ||
                               gap_q == 8'(RATIO2) || gap_q == 8'(RATIO3)));

  // R2: prescaler pulse is one cycle wide
  a_r2_pre_single: assert property (@(posedge clk) disable iff (rst)
    pre_pulse |=> !pre_pulse);

  // R2: cascaded second-stage pulse is one cycle wide
  a_r2_div_single: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && cascade_mode) |=> (!div_pulse || !cascade_mode));

  // R4 / R5: second stage only fires on its selected advance source
  a_r4_div_source: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (cascade_mode ? pre_pulse : aux_tick));

  // R8: zero preset keeps the second stage silent
  a_r8_zero_silent: assert property (@(posedge clk) disable iff (rst)
    zero_err |-> !div_pulse);

  // R9: cleared prescaler cannot be at terminal count right after reset
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> !pre_pulse);

endmodule

bind divchain_top divchain_chk #(
  .RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2), .RATIO3(RATIO3)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cascade_mode(cascade_mode),
  .aux_tick    (aux_tick),
  .pre_pulse   (pre_pulse),
  .div_pulse   (div_pulse),
  .zero_err    (zero_err)
);

// File: tb/divchain_top_tb_top.sv
module divchain_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       sel_hi = 1'b0, sel_lo = 1'b0;
  logic [3:0] preset = 4'd1;
  logic       preset_en = 1'b1;
  logic       cascade_mode = 1'b1;
  logic       aux_tick = 1'b0;
  logic       pre_pulse, div_pulse, cmp_feed, zero_err;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  divchain_top dut_i (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .preset(preset), .preset_en(preset_en), .cascade_mode(cascade_mode),
    .aux_tick(aux_tick), .pre_pulse(pre_pulse), .div_pulse(div_pulse),
    .cmp_feed(cmp_feed), .zero_err(zero_err)
  );

  // {cascade, sel[1:0], N[3:0], expected cmp_feed period[11:0]}
  localparam logic [18:0] VEC [12] = '{
    {1'b1, 2'b00, 4'd1,  12'd4},
    {1'b1, 2'b01, 4'd3,  12'd48},
    {1'b1, 2'b10, 4'd2,  12'd128},
    {1'b1, 2'b11, 4'd1,  12'd100},
    {1'b1, 2'b11, 4'd15, 12'd1500},
    {1'b1, 2'b00, 4'd15, 12'd60},
    {1'b1, 2'b01, 4'd7,  12'd112},
    {1'b1, 2'b10, 4'd5,  12'd320},
    {1'b0, 2'b00, 4'd9,  12'd4},
    {1'b0, 2'b01, 4'd5,  12'd16},
    {1'b0, 2'b10, 4'd0,  12'd64},
    {1'b0, 2'b11, 4'd3,  12'd100}
  };

  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 100;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0:       return cmp_feed;
      1:       return pre_pulse;
      default: return div_pulse;
    endcase
  endfunction

  // Count negedges until the chosen output is seen high (at least one step)
  task automatic next_pulse(input int which, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pick(which) && n < 4000);
    if (!pick(which)) n = -1;
  endtask

  task automatic do_reset(input logic [1:0] s, input logic [3:0] n, input logic casc);
    @(negedge clk);
    {sel_hi, sel_lo} = s;
    preset = n;
    cascade_mode = casc;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int p;
    int q;

    // R9: outputs quiet while reset is held; R8: zero preset flagged at reset
    do_reset(2'b00, 4'd0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check(!pre_pulse && !div_pulse && !cmp_feed, "R9 reset outputs low",
          {pre_pulse, div_pulse, cmp_feed}, 0);
    check(zero_err == 1'b1, "R8 zero flag after reset", zero_err, 1);
    rst = 1'b0;

    // Vector table: R1, R3, R4, R5
    foreach (VEC[i]) begin
      do_reset(VEC[i][17:16], VEC[i][15:12], VEC[i][18]);
      next_pulse(0, p);
      next_pulse(0, p);
      check(p == int'(VEC[i][11:0]),
            VEC[i][18] ? "R4 cascade period" : "R5 independent feed period",
            p, int'(VEC[i][11:0]));
    end

    // Full sweep, cascade: R1, R3, R4
    for (int r = 0; r < 4; r++) begin
      for (int n = 1; n < 16; n++) begin
        do_reset(2'(r), 4'(n), 1'b1);
        next_pulse(0, p);
        next_pulse(0, p);
        check(p == ratio_of(2'(r)) * n, "R3 sweep ratio*N", p, ratio_of(2'(r)) * n);
      end
    end

    // Prescaler alone, every ratio: R1
    for (int r = 0; r < 4; r++) begin
      do_reset(2'(r), 4'd1, 1'b0);
      next_pulse(1, p);
      next_pulse(1, p);
      check(p == ratio_of(2'(r)), "R1 prescaler ratio", p, ratio_of(2'(r)));
    end

    // R2: pulse width one cycle
    do_reset(2'b00, 4'd2, 1'b1);
    next_pulse(1, p);
    @(negedge clk);
    check(!pre_pulse, "R2 pre_pulse one cycle", pre_pulse, 0);
    next_pulse(2, p);
    @(negedge clk);
    check(!div_pulse, "R2 div_pulse one cycle", div_pulse, 0);

    // R7: ratio change mid-period completes the old period
    do_reset(2'b11, 4'd1, 1'b1);
    next_pulse(1, p);
    repeat (10) @(negedge clk);
    {sel_hi, sel_lo} = 2'b00;
    next_pulse(1, p);
    check(p + 10 == 100, "R7 old ratio completes", p + 10, 100);
    next_pulse(1, p);
    check(p == 4, "R7 new ratio applied", p, 4);

    // R6: preset change taken at terminal count
    preset_en = 1'b1;
    do_reset(2'b00, 4'd3, 1'b1);
    next_pulse(0, p);
    repeat (2) @(negedge clk);
    preset = 4'd5;
    next_pulse(0, p);
    check(p + 2 == 12, "R6 old N completes", p + 2, 12);
    next_pulse(0, p);
    check(p == 20, "R6 new N applied", p, 20);
    preset_en = 1'b0;
    preset = 4'd2;
    next_pulse(0, p);
    next_pulse(0, q);
    check(p == 20 && q == 20, "R6 preset ignored without enable", q, 20);
    preset_en = 1'b1;

    // R5: independent mode, second stage follows aux_tick only
    do_reset(2'b01, 4'd3, 1'b0);
    aux_tick = 1'b0;
    q = 0;
    repeat (60) begin
      @(negedge clk);
      if (div_pulse) q++;
    end
    check(q == 0, "R5 no aux_tick no div_pulse", q, 0);
    aux_tick = 1'b1;
    next_pulse(2, p);
    next_pulse(2, p);
    check(p == 3, "R5 div period on aux_tick", p, 3);
    next_pulse(0, p);
    next_pulse(0, p);
    check(p == 16, "R5 cmp_feed follows prescaler", p, 16);
    aux_tick = 1'b0;

    // R8: zero preset silent, then recovery
    do_reset(2'b00, 4'd0, 1'b1);
    q = 0;
    repeat (200) begin
      @(negedge clk);
      if (div_pulse || cmp_feed || !zero_err) q++;
    end
    check(q == 0, "R8 zero preset holds output low", q, 0);
    preset = 4'd6;
    repeat (8) @(negedge clk);
    check(zero_err == 1'b0, "R8 zero flag clears on load", zero_err, 0);
    next_pulse(0, p);
    next_pulse(0, p);
    check(p == 24, "R8 period after recovery", p, 24);

    finish_run();
  end
endmodule